// File: doc/BRIEF.md
# Indirect-Pointer Register File for a Two-Channel Serial Controller

This block is the host-visible register bank of a two-channel serial controller. Each channel has its own access port, made of a control strobe pair, a data strobe pair, a write byte and a read byte. Only register 0 of a channel can be reached directly. The host selects any other register by writing its number into register 0. The next control access on that channel, read or write, then lands on the selected register, and the channel's pointer falls back to 0 afterwards.

The block stores up to sixteen write registers per channel and exposes them as a flat image for the rest of the controller. It drives the modem request and ready lines from the modem-control register and emits a one-cycle load pulse with the byte whenever the transmit data register is written. Read registers are assembled from live per-channel status inputs: receive byte waiting, transmit buffer empty, carrier detect, clear-to-send and transmitter idle. Read registers also return the stored baud time-constant bytes. One master interrupt control register exists only once and is reachable from both channels. Serial shifting, baud generation and interrupt priority logic live elsewhere.

Top module: `sio_regfile`

## Requirements
- R1: A synchronous reset clears every write register and the pointer of each channel, so the whole register image reads zero. Modem outputs, the interrupt control outputs and the load pulse go low.
- R2: A control write while a channel's pointer is 0 stores the byte in write register 0. It also loads the pointer with bits 2:0 of the byte plus 8 when bit 3 is set. The next control write stores its byte in the register so selected, at slot `(ch*16+reg)*8` of the image.
- R3: After any control read, and after any control write made with a nonzero pointer, the channel's pointer is 0 again. The following control read returns read register 0.
- R4: Read register 0 holds receive-byte-available in bit 0, transmit-empty in bit 2, carrier detect in bit 3 and clear-to-send in bit 5. All other bits read 0.
- R5: Read register 1 holds transmitter-idle in bit 0 and zeros elsewhere. A control read of any register other than 0, 1, 8, 12 or 13 returns 0.
- R6: A read of the data port returns the channel's received byte, and so does a control read of register 8.
- R7: Write registers 12 (time-constant low byte) and 13 (high byte) read back through control reads with their stored values.
- R8: Bit 1 of write register 5 drives the channel's request-to-send output and bit 7 drives its terminal-ready output. These outputs change only after a control write.
- R9: Write register 9 exists once. A write from either channel sets the master-interrupt-enable output from bit 3 and the vector-status output from bit 0, and the value appears at slot 9 of both channels' images. If both channels write it in the same cycle, channel 0's byte is kept.
- R10: A data port write, or a control write to register 8, stores the byte at slot 8. The cycle after, it raises that channel's load pulse for one cycle with the byte on the transmit output. Data port accesses leave the pointer unchanged.
- R11: The two channels' pointers and registers are independent. An access on one channel never changes what the other channel's next control access reaches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 2 | Control port write strobe, one bit per channel |
| ctl_rd | input | 2 | Control port read strobe, one bit per channel |
| dat_wr | input | 2 | Data port write strobe, one bit per channel |
| dat_rd | input | 2 | Data port read strobe, one bit per channel |
| host_wdata | input | 16 | Write byte per channel (channel c at bits c*8+7:c*8) |
| host_rdata | output | 16 | Read byte per channel, combinational during a read strobe |
| st_rx_avail | input | 2 | Received byte waiting, per channel |
| st_tx_empty | input | 2 | Transmit buffer empty, per channel |
| st_all_sent | input | 2 | Transmitter fully idle, per channel |
| st_dcd | input | 2 | Carrier detect, per channel |
| st_cts | input | 2 | Clear-to-send, per channel |
| rx_byte | input | 16 | Received byte per channel |
| tx_byte | output | 16 | Stored transmit byte per channel |
| tx_load | output | 2 | One-cycle pulse after a transmit byte write |
| modem_rts | output | 2 | Request-to-send per channel |
| modem_dtr | output | 2 | Terminal-ready per channel |
| irq_master_en | output | 1 | Master interrupt enable from the shared register |
| vec_incl_status | output | 1 | Vector-includes-status from the shared register |
| wreg_image | output | 256 | All write registers, 16 bytes per channel |

## Verification
The shared interrupt control register is the one place where the two channels meet. Both channels can finish an indirect write to it in the same clock. The bench points both channels at register 9 and then raises both control write strobes together with different bytes, once in each order of the two values. It judges the outcome through the interrupt outputs and slot 9 of both images, which must carry channel 0's byte. It then checks that both pointers went back to 0 and that the losing channel's own state is untouched.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // register numbers whose meaning the logic depends on
    localparam int REG_CMD    = 0;
    localparam int REG_IDLE   = 1;
    localparam int REG_MODEM  = 5;
    localparam int REG_DATA   = 8;
    localparam int REG_SHARED = 9;
    localparam int REG_TC_LO  = 12;
    localparam int REG_TC_HI  = 13;

    // bit positions
    localparam int CMD_HIGH_BIT = 3;
    localparam int RTS_BIT      = 1;
    localparam int DTR_BIT      = 7;
    localparam int MIE_BIT      = 3;
    localparam int VIS_BIT      = 0;

    typedef struct packed {
        logic rx_avail;
        logic tx_empty;
        logic all_sent;
        logic dcd;
        logic cts;
    } chan_stat_t;

    function automatic byte_t rr0_pack(input chan_stat_t s);
        byte_t v;
        v    = '0;
        v[0] = s.rx_avail;
        v[2] = s.tx_empty;
        v[3] = s.dcd;
        v[5] = s.cts;
        return v;
    endfunction

    function automatic byte_t rr1_pack(input chan_stat_t s);
        byte_t v;
        v    = '0;
        v[0] = s.all_sent;
        return v;
    endfunction

    // register number carried by a command byte: low three bits plus 8 when high flag set
    function automatic logic [3:0] cmd_target(input byte_t b);
        return {b[CMD_HIGH_BIT], b[2:0]};
    endfunction

endpackage

// File: rtl/sio_ptr.sv
module sio_ptr #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    input  logic          clear,
    output logic [PW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (clear) begin
            ptr <= '0;
        end
    end
endmodule

// File: rtl/sio_shared_reg.sv
module sio_shared_reg
    import sio_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        we,
    input  logic [NCH*BYTE_W-1:0] wd,
    output byte_t                 q
);
    logic  pick_we;
    byte_t pick_d;

    // lowest channel index wins: it is assigned last
    always_comb begin
        pick_we = 1'b0;
        pick_d  = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (we[c]) begin
                pick_we = 1'b1;
                pick_d  = wd[c*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (pick_we) begin
            q <= pick_d;
        end
    end
endmodule

// File: rtl/sio_chan_regs.sv
module sio_chan_regs
    import sio_pkg::*;
#(
    parameter  int NREG = 16,
    localparam int PW   = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ctl_wr,
    input  logic                   ctl_rd,
    input  logic                   dat_wr,
    input  logic                   dat_rd,
    input  byte_t                  wdata,
    input  chan_stat_t             stat,
    input  byte_t                  rx_byte,
    input  byte_t                  shared_cfg,
    output logic                   shared_we,
    output byte_t                  rdata,
    output logic [NREG*BYTE_W-1:0] image,
    output logic                   tx_load,
    output logic                   rts,
    output logic                   dtr,
    output logic [PW-1:0]          ptr
);
    logic            ptr_zero;
    logic            ptr_load;
    logic            ptr_clear;
    logic [PW-1:0]   ptr_next;
    logic [NREG-1:0] we;
    byte_t           ctl_val;

    assign ptr_zero  = (ptr == '0);
    assign ptr_load  = ctl_wr && ptr_zero;
    assign ptr_clear = ctl_rd || (ctl_wr && !ptr_zero);
    assign ptr_next  = PW'(cmd_target(wdata));

    sio_ptr #(.PW(PW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .load    (ptr_load),
        .load_val(ptr_next),
        .clear   (ptr_clear),
        .ptr     (ptr)
    );

    // per-register write enables; the data port aliases the transmit register
    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            we[r] = ctl_wr && (ptr == PW'(r));
        end
        we[REG_DATA] = we[REG_DATA] || dat_wr;
    end

    assign shared_we = we[REG_SHARED];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        if (r == REG_SHARED) begin : g_alias
            assign image[r*BYTE_W +: BYTE_W] = shared_cfg;
        end else begin : g_store
            byte_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (we[r]) begin
                    q <= wdata;
                end
            end
            assign image[r*BYTE_W +: BYTE_W] = q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_load <= 1'b0;
        end else begin
            tx_load <= we[REG_DATA];
        end
    end

    assign rts = image[REG_MODEM*BYTE_W + RTS_BIT];
    assign dtr = image[REG_MODEM*BYTE_W + DTR_BIT];

    always_comb begin
        case (int'(ptr))
            REG_CMD:   ctl_val = rr0_pack(stat);
            REG_IDLE:  ctl_val = rr1_pack(stat);
            REG_DATA:  ctl_val = rx_byte;
            REG_TC_LO: ctl_val = image[REG_TC_LO*BYTE_W +: BYTE_W];
            REG_TC_HI: ctl_val = image[REG_TC_HI*BYTE_W +: BYTE_W];
            default:   ctl_val = '0;
        endcase
        if (ctl_rd) begin
            rdata = ctl_val;
        end else if (dat_rd) begin
            rdata = rx_byte;
        end else begin
            rdata = '0;
        end
    end
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
    import sio_pkg::*;
#(
    parameter  int NCH  = 2,
    parameter  int NREG = 16,
    localparam int PW   = $clog2(NREG),
    localparam int CW   = NCH * BYTE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCH-1:0]             ctl_wr,
    input  logic [NCH-1:0]             ctl_rd,
    input  logic [NCH-1:0]             dat_wr,
    input  logic [NCH-1:0]             dat_rd,
    input  logic [CW-1:0]              host_wdata,
    output logic [CW-1:0]              host_rdata,
    input  logic [NCH-1:0]             st_rx_avail,
    input  logic [NCH-1:0]             st_tx_empty,
    input  logic [NCH-1:0]             st_all_sent,
    input  logic [NCH-1:0]             st_dcd,
    input  logic [NCH-1:0]             st_cts,
    input  logic [CW-1:0]              rx_byte,
    output logic [CW-1:0]              tx_byte,
    output logic [NCH-1:0]             tx_load,
    output logic [NCH-1:0]             modem_rts,
    output logic [NCH-1:0]             modem_dtr,
    output logic                       irq_master_en,
    output logic                       vec_incl_status,
    output logic [NCH*NREG*BYTE_W-1:0] wreg_image
);
    localparam int IMG_W = NREG * BYTE_W;

    byte_t           shared_q;
    logic [NCH-1:0]  shared_we;
    logic [NCH*PW-1:0] ptr_flat;

    sio_shared_reg #(.NCH(NCH)) u_shared (
        .clk(clk),
        .rst(rst),
        .we (shared_we),
        .wd (host_wdata),
        .q  (shared_q)
    );

    assign irq_master_en   = shared_q[MIE_BIT];
    assign vec_incl_status = shared_q[VIS_BIT];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_stat_t st;
        assign st.rx_avail = st_rx_avail[c];
        assign st.tx_empty = st_tx_empty[c];
        assign st.all_sent = st_all_sent[c];
        assign st.dcd      = st_dcd[c];
        assign st.cts      = st_cts[c];

        sio_chan_regs #(.NREG(NREG)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .ctl_wr    (ctl_wr[c]),
            .ctl_rd    (ctl_rd[c]),
            .dat_wr    (dat_wr[c]),
            .dat_rd    (dat_rd[c]),
            .wdata     (host_wdata[c*BYTE_W +: BYTE_W]),
            .stat      (st),
            .rx_byte   (rx_byte[c*BYTE_W +: BYTE_W]),
            .shared_cfg(shared_q),
            .shared_we (shared_we[c]),
            .rdata     (host_rdata[c*BYTE_W +: BYTE_W]),
            .image     (wreg_image[c*IMG_W +: IMG_W]),
            .tx_load   (tx_load[c]),
            .rts       (modem_rts[c]),
            .dtr       (modem_dtr[c]),
            .ptr       (ptr_flat[c*PW +: PW])
        );

        assign tx_byte[c*BYTE_W +: BYTE_W] =
            wreg_image[c*IMG_W + REG_DATA*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/sio_regfile_chk.sv
module sio_regfile_chk #(
    parameter int NCH = 2,
    parameter int PW  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    ctl_wr,
    input logic [NCH-1:0]    ctl_rd,
    input logic [NCH-1:0]    dat_wr,
    input logic [NCH-1:0]    tx_load,
    input logic [NCH-1:0]    modem_rts,
    input logic [NCH-1:0]    modem_dtr,
    input logic              irq_master_en,
    input logic              vec_incl_status,
    input logic [NCH*PW-1:0] ptr_flat
);
    // R1: the cycle after reset everything driven outward is quiet
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (modem_rts == '0 && modem_dtr == '0 && tx_load == '0
                        && !irq_master_en && !vec_incl_status));

    // R9: shared register outputs only move after some control write
    assert_shared_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(|ctl_wr) && !$past(rst)) |-> ($stable(irq_master_en) && $stable(vec_incl_status)));

    for (genvar c = 0; c < NCH; c++) begin : g_c
        // R10: a data port write is followed by the load pulse
        assert_tx_follows_write_R10: assert property (@(posedge clk) disable iff (rst)
            dat_wr[c] |=> tx_load[c]);

        // R8: modem lines only move after a control write on the same channel
        assert_modem_stable_R8: assert property (@(posedge clk) disable iff (rst)
            (!$past(ctl_wr[c]) && !$past(rst)) |-> ($stable(modem_rts[c]) && $stable(modem_dtr[c])));

        // R3: an indirect access leaves the pointer at zero
        assert_ptr_return_R3: assert property (@(posedge clk) disable iff (rst)
            ($past(ctl_rd[c] || ctl_wr[c]) && !$past(ctl_wr[c] && ptr_flat[c*PW +: PW] == '0))
            |-> (ptr_flat[c*PW +: PW] == '0));
    end
endmodule

bind sio_regfile sio_regfile_chk #(.NCH(NCH), .PW(PW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ctl_wr         (ctl_wr),
    .ctl_rd         (ctl_rd),
    .dat_wr         (dat_wr),
    .tx_load        (tx_load),
    .modem_rts      (modem_rts),
    .modem_dtr      (modem_dtr),
    .irq_master_en  (irq_master_en),
    .vec_incl_status(vec_incl_status),
    .ptr_flat       (ptr_flat)
);

// File: tb/tb_sio_regfile.sv
`timescale 1ns/100ps
module tb_sio_regfile;
    localparam int NCH = 2;
    localparam int NREG = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0]   ctl_wr = '0, ctl_rd = '0, dat_wr = '0, dat_rd = '0;
    logic [15:0]  host_wdata = '0;
    logic [15:0]  host_rdata;
    logic [1:0]   st_rx_avail, st_tx_empty, st_all_sent, st_dcd, st_cts;
    logic [15:0]  rx_byte;
    logic [15:0]  tx_byte;
    logic [1:0]   tx_load, modem_rts, modem_dtr;
    logic         irq_master_en, vec_incl_status;
    logic [255:0] wreg_image;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sio_regfile #(.NCH(NCH), .NREG(NREG)) dut (.*);

    localparam logic [1:0] OP_CW = 2'd0, OP_CR = 2'd1, OP_DW = 2'd2, OP_DR = 2'd3;
    localparam int NV = 25;
    // {req, ch, op, wdata, expected read}; ch0 RR0 = 25, ch1 RR0 = 0C
    localparam logic [22:0] VEC [NV] = '{
        {4'd4,  1'b0, OP_CR, 8'h00, 8'h25},  // R4
        {4'd4,  1'b1, OP_CR, 8'h00, 8'h0C},  // R4
        {4'd2,  1'b0, OP_CW, 8'h0C, 8'h00},  // R2 point high -> 12
        {4'd2,  1'b0, OP_CW, 8'h34, 8'h00},
        {4'd3,  1'b0, OP_CR, 8'h00, 8'h25},  // R3
        {4'd2,  1'b0, OP_CW, 8'h0D, 8'h00},
        {4'd2,  1'b0, OP_CW, 8'h12, 8'h00},
        {4'd7,  1'b0, OP_CW, 8'h0C, 8'h00},
        {4'd7,  1'b0, OP_CR, 8'h00, 8'h34},  // R7
        {4'd7,  1'b0, OP_CW, 8'h0D, 8'h00},
        {4'd7,  1'b0, OP_CR, 8'h00, 8'h12},  // R7
        {4'd5,  1'b0, OP_CW, 8'h01, 8'h00},
        {4'd5,  1'b0, OP_CR, 8'h00, 8'h01},  // R5
        {4'd5,  1'b1, OP_CW, 8'h01, 8'h00},
        {4'd5,  1'b1, OP_CR, 8'h00, 8'h00},  // R5
        {4'd6,  1'b0, OP_CW, 8'h08, 8'h00},
        {4'd6,  1'b0, OP_CR, 8'h00, 8'hA5},  // R6
        {4'd6,  1'b1, OP_DR, 8'h00, 8'h3C},  // R6
        {4'd5,  1'b1, OP_CW, 8'h03, 8'h00},
        {4'd5,  1'b1, OP_CR, 8'h00, 8'h00},  // R5
        {4'd3,  1'b1, OP_CR, 8'h00, 8'h0C},  // R3
        {4'd11, 1'b0, OP_CW, 8'h0C, 8'h00},
        {4'd11, 1'b1, OP_CR, 8'h00, 8'h0C},  // R11
        {4'd10, 1'b0, OP_DR, 8'h00, 8'hA5},  // R10 data port leaves pointer
        {4'd11, 1'b0, OP_CR, 8'h00, 8'h34}   // R11
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input int ch, input logic [1:0] op, input logic [7:0] d,
                         output logic [7:0] rd);
        @(negedge clk);
        host_wdata[ch*8 +: 8] = d;
        case (op)
            OP_CW: ctl_wr[ch] = 1'b1;
            OP_CR: ctl_rd[ch] = 1'b1;
            OP_DW: dat_wr[ch] = 1'b1;
            default: dat_rd[ch] = 1'b1;
        endcase
        #1 rd = host_rdata[ch*8 +: 8];
        @(posedge clk);
        #0.5;
        ctl_wr = '0; ctl_rd = '0; dat_wr = '0; dat_rd = '0;
    endtask

    function automatic logic [7:0] slot(input int ch, input int r);
        return wreg_image[(ch*16 + r)*8 +: 8];
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        st_rx_avail = 2'b01; st_tx_empty = 2'b11; st_all_sent = 2'b01;
        st_dcd = 2'b10; st_cts = 2'b01;
        rx_byte = {8'h3C, 8'hA5};
        repeat (3) @(posedge clk);
        #0.5 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 image", {7'd0, (wreg_image != '0)}, 8'h00);
        chk("R1 modem", {4'd0, modem_rts, modem_dtr}, 8'h00);
        chk("R1 irq", {6'd0, irq_master_en, vec_incl_status}, 8'h00);
        chk("R1 load", {6'd0, tx_load}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            v = VEC[i];
            do_op(int'(v[18]), v[17:16], v[15:8], rd);
            if (v[17:16] == OP_CR || v[17:16] == OP_DR)
                chk($sformatf("R%0d vector %0d", v[22:19], i), rd, v[7:0]);
        end

        // R2 image slots
        @(negedge clk);
        chk("R2 slot0", slot(0, 0), 8'h0C);
        chk("R2 slot12", slot(0, 12), 8'h34);
        chk("R7 slot13", slot(0, 13), 8'h12);

        // R8 modem lines
        do_op(1, OP_CW, 8'h05, rd);
        do_op(1, OP_CW, 8'h82, rd);
        @(negedge clk);
        chk("R8 ch1 rts/dtr", {6'd0, modem_rts[1], modem_dtr[1]}, 8'h03);
        chk("R8 ch0 quiet", {6'd0, modem_rts[0], modem_dtr[0]}, 8'h00);
        do_op(1, OP_CW, 8'h05, rd);
        do_op(1, OP_CW, 8'h02, rd);
        @(negedge clk);
        chk("R8 dtr drop", {6'd0, modem_rts[1], modem_dtr[1]}, 8'h02);

        // R9 shared register, single write
        do_op(1, OP_CW, 8'h09, rd);
        do_op(1, OP_CW, 8'h09, rd);
        @(negedge clk);
        chk("R9 mie/vis", {6'd0, irq_master_en, vec_incl_status}, 8'h03);
        chk("R9 ch0 alias", slot(0, 9), 8'h09);

        // R9 collision: channel 0 wins
        do_op(0, OP_CW, 8'h09, rd);
        do_op(1, OP_CW, 8'h09, rd);
        @(negedge clk);
        host_wdata = {8'h01, 8'h08};
        ctl_wr = 2'b11;
        @(posedge clk);
        #0.5 ctl_wr = '0;
        @(negedge clk);
        chk("R9 collision a", {6'd0, irq_master_en, vec_incl_status}, 8'h02);
        chk("R9 collision slot", slot(1, 9), 8'h08);
        do_op(0, OP_CW, 8'h09, rd);
        do_op(1, OP_CW, 8'h09, rd);
        @(negedge clk);
        host_wdata = {8'h08, 8'h01};
        ctl_wr = 2'b11;
        @(posedge clk);
        #0.5 ctl_wr = '0;
        @(negedge clk);
        chk("R9 collision b", {6'd0, irq_master_en, vec_incl_status}, 8'h01);
        do_op(0, OP_CR, 8'h00, rd);
        chk("R3 after collision ch0", rd, 8'h25);
        do_op(1, OP_CR, 8'h00, rd);
        chk("R3 after collision ch1", rd, 8'h0C);
        chk("R11 ch1 modem kept", slot(1, 5), 8'h02);

        // R10 transmit load via data port, pointer untouched
        do_op(0, OP_CW, 8'h0C, rd);
        do_op(0, OP_DW, 8'h5A, rd);
        @(negedge clk);
        chk("R10 pulse", {6'd0, tx_load}, 8'h01);
        chk("R10 byte", tx_byte[7:0], 8'h5A);
        @(negedge clk);
        chk("R10 pulse end", {6'd0, tx_load}, 8'h00);
        do_op(0, OP_CR, 8'h00, rd);
        chk("R10 pointer kept", rd, 8'h34);
        // R10 via indirect register 8
        do_op(1, OP_CW, 8'h08, rd);
        do_op(1, OP_CW, 8'h77, rd);
        @(negedge clk);
        chk("R10 indirect pulse", {6'd0, tx_load}, 8'h02);
        chk("R10 indirect byte", tx_byte[15:8], 8'h77);

        // R4 live status change
        st_cts[1] = 1'b1; st_dcd[1] = 1'b0;
        do_op(1, OP_CR, 8'h00, rd);
        chk("R4 live status", rd, 8'h24);

        // R1 reset in mid run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #0.5 rst = 1'b0;
        @(negedge clk);
        chk("R1 image after reset", {7'd0, (wreg_image != '0)}, 8'h00);
        chk("R1 outputs after reset", {2'd0, modem_rts, modem_dtr, irq_master_en, vec_incl_status}, 8'h00);
        do_op(0, OP_CR, 8'h00, rd);
        chk("R1 pointer after reset", rd, 8'h25);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule